// File: doc/BRIEF.md
# Two-Player LED Table-Tennis Game Controller

This block runs a table-tennis game for two players on a row of LEDs. The ball is a position counter with `LEDS + 2` values. The values 1 to `LEDS` light one LED each. The two values at either end mean the ball has left the table. Player A defends the low end and player B defends the high end. The ball moves one place on each cycle in which the slow speed tick is high, so the speed of play follows the rate of that tick.

Each player has a paddle input. A paddle press counts as a hit only when the ball sits on that player's own end LED. A hit sends the ball back toward the other side. If the ball passes a player's end without a hit, it leaves the table and the opponent scores one point. The serving side owns the ball while it waits on the server's end LED, and only that side can launch it. Serve ownership passes to the other player after every two launches. A pickup control puts the ball back on the current server's end LED. A referee clear starts a new game. The game ends when either score reaches the winning value.

Top module: `pong_core`

## Requirements
- R1: After reset, `led_o` is 8'b0000_0001 (ball on A's end), `serve_led_o` is 2'b01 (bit0 = A serves, bit1 = B serves), both scores are 0 and `game_over_o` is 0.
- R2: `led_o` has only bit k-1 set when the ball is at position k (1..8). It is all zero when the ball is off the table.
- R3: When the ball waits on the server's end, a press by the server launches it. A sends it toward `led_o[7]` and B toward `led_o[0]`. The ball then moves one position on each cycle with `tick_i` high.
- R4: Before a launch, `tick_i` does not move the ball, and a press by the player who is not serving has no effect.
- R5: During a rally, a press by a player whose end LED is lit sends the ball back toward the other end. A press while the ball is on any other LED is ignored.
- R6: A ball that passes an end without a hit goes off the table, and the opponent's score rises by one, only once. The ball then stays off the table (ticks and presses have no effect) until a pickup.
- R7: A pickup puts the ball on the current server's end at the next clock edge (`led_o[0]` for A, `led_o[7]` for B) and stops it.
- R8: Serve ownership passes to the other player after every second launch. The change is visible on `serve_led_o` right after the launch that completes the pair.
- R9: A score never goes above 11. `game_over_o` is 1 while either score is 11, and during that time no point is scored and no launch is accepted.
- R10: A referee clear sets both scores to 0, which drops `game_over_o`.
- R11: A paddle held high counts as one press, on its rising edge only. Holding it high while the ball arrives at that player's end is not a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Ball speed tick, one step per high cycle |
| paddle_a_i | input | 1 | Debounced paddle of player A (low end) |
| paddle_b_i | input | 1 | Debounced paddle of player B (high end) |
| pickup_i | input | 1 | Put the ball back on the server's end |
| ref_clr_i | input | 1 | Referee clear of both scores |
| led_o | output | 8 | One-hot ball position |
| serve_led_o | output | 2 | Serve ownership, bit0 A, bit1 B |
| score_a_o | output | 4 | Score of player A |
| score_b_o | output | 4 | Score of player B |
| game_over_o | output | 1 | A score has reached the winning value |

## Verification
The hardest state to reach is the end of a game. Getting there needs dozens of complete rallies, each with a pickup, a launch by whoever holds the serve at that moment, and a run of ticks that carries the ball off the far end. The bench drives these rallies in a loop. It tracks serve ownership and both scores arithmetically from the two-launch rule, and checks each of them after every rally. Once a score reaches the winning value, it checks that launch and scoring are both blocked, and then that the referee clear restarts the game. Before that, directed rallies cover a rebound, ignored presses away from an end, and a paddle held high across the ball's arrival.

// File: rtl/pong_pkg.sv
package pong_pkg;
  typedef enum logic {SIDE_A = 1'b0, SIDE_B = 1'b1} side_e;
  typedef enum logic {DIR_DN = 1'b0, DIR_UP = 1'b1} dir_e;
endpackage

// File: rtl/pong_ball.sv
module pong_ball
  import pong_pkg::*;
#(
  parameter int LEDS  = 8,
  parameter int POS_W = $clog2(LEDS + 2)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            hit_a_i,
  input  logic            hit_b_i,
  input  logic            pickup_i,
  input  logic            play_en_i,
  input  side_e           server_i,
  output logic            launch_o,
  output logic            miss_a_o,
  output logic            miss_b_o,
  output logic [LEDS-1:0] led_o
);
  localparam logic [POS_W-1:0] POS_A   = POS_W'(1);
  localparam logic [POS_W-1:0] POS_B   = POS_W'(LEDS);
  localparam logic [POS_W-1:0] POS_MAX = POS_W'(LEDS + 1);

  logic [POS_W-1:0] pos_q, pos_nxt;
  dir_e             dir_q, dir_nxt;
  logic             moving_q;
  logic             at_a, at_b, out_of_table, step, reb_a, reb_b;

  assign at_a         = (pos_q == POS_A);
  assign at_b         = (pos_q == POS_B);
  assign out_of_table = (pos_q == '0) || (pos_q == POS_MAX);

  // serve only from rest on the server's own end
  assign launch_o = !moving_q && !pickup_i && play_en_i &&
                    (((server_i == SIDE_A) && at_a && hit_a_i) ||
                     ((server_i == SIDE_B) && at_b && hit_b_i));
  assign reb_a    = moving_q && at_a && hit_a_i;
  assign reb_b    = moving_q && at_b && hit_b_i;

  always_comb begin
    dir_nxt = dir_q;
    if (launch_o)   dir_nxt = (server_i == SIDE_A) ? DIR_UP : DIR_DN;
    else if (reb_a) dir_nxt = DIR_UP;
    else if (reb_b) dir_nxt = DIR_DN;
  end

  assign step     = tick_i && !pickup_i && (moving_q || launch_o);
  assign pos_nxt  = (dir_nxt == DIR_UP) ? pos_q + POS_W'(1) : pos_q - POS_W'(1);
  assign miss_a_o = step && at_a && (dir_nxt == DIR_DN);
  assign miss_b_o = step && at_b && (dir_nxt == DIR_UP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q    <= POS_A;
      dir_q    <= DIR_UP;
      moving_q <= 1'b0;
    end else if (pickup_i) begin
      pos_q    <= (server_i == SIDE_A) ? POS_A : POS_B;
      dir_q    <= (server_i == SIDE_A) ? DIR_UP : DIR_DN;
      moving_q <= 1'b0;
    end else begin
      dir_q <= dir_nxt;
      if (step) pos_q <= pos_nxt;
      if (miss_a_o || miss_b_o) moving_q <= 1'b0;
      else if (launch_o)        moving_q <= 1'b1;
    end
  end

  for (genvar i = 0; i < LEDS; i++) begin : g_led
    assign led_o[i] = (pos_q == POS_W'(i + 1));
  end

  p_pos_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_q <= POS_MAX);
  p_out_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_of_table && !pickup_i) |=> $stable(pos_q));
  p_pickup_end_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pickup_i |=> ((pos_q == POS_A) || (pos_q == POS_B)) && !moving_q);
  p_no_tick_still_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !pickup_i) |=> $stable(pos_q));
endmodule

// File: rtl/pong_score.sv
module pong_score #(
  parameter int W   = 4,
  parameter int WIN = 11
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] score_o,
  output logic         win_o
);
  localparam logic [W-1:0] WIN_V = W'(WIN);

  logic [W-1:0] score_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        score_q <= '0;
    else if (clr_i)                     score_q <= '0;
    else if (inc_i && score_q != WIN_V) score_q <= score_q + W'(1);
  end

  assign score_o = score_q;
  assign win_o   = (score_q == WIN_V);

  p_sat_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (score_q == WIN_V && !clr_i) |=> (score_q == WIN_V));
  p_single_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (score_q == $past(score_q)) || (score_q == $past(score_q) + W'(1)));
endmodule

// File: rtl/pong_serve.sv
module pong_serve
  import pong_pkg::*;
#(
  parameter int SERVES = 2,
  parameter int CNT_W  = $clog2(SERVES + 1)
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  launch_i,
  output side_e owner_o
);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SERVES - 1);

  logic [CNT_W-1:0] cnt_q;
  side_e            owner_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      owner_q <= SIDE_A;
    end else if (launch_i) begin
      if (cnt_q == CNT_LAST) begin
        cnt_q   <= '0;
        owner_q <= (owner_q == SIDE_A) ? SIDE_B : SIDE_A;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign owner_o = owner_q;

  p_owner_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !launch_i |=> $stable(owner_q));
endmodule

// File: rtl/pong_core.sv
module pong_core
  import pong_pkg::*;
#(
  parameter int LEDS    = 8,
  parameter int SCORE_W = 4,
  parameter int WIN     = 11,
  parameter int SERVES  = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               paddle_a_i,
  input  logic               paddle_b_i,
  input  logic               pickup_i,
  input  logic               ref_clr_i,
  output logic [LEDS-1:0]    led_o,
  output logic [1:0]         serve_led_o,
  output logic [SCORE_W-1:0] score_a_o,
  output logic [SCORE_W-1:0] score_b_o,
  output logic               game_over_o
);
  logic  pad_a_q, pad_b_q, hit_a, hit_b;
  logic  launch, miss_a, miss_b, win_a, win_b;
  side_e owner;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pad_a_q <= 1'b0;
      pad_b_q <= 1'b0;
    end else begin
      pad_a_q <= paddle_a_i;
      pad_b_q <= paddle_b_i;
    end
  end

  assign hit_a = paddle_a_i && !pad_a_q;
  assign hit_b = paddle_b_i && !pad_b_q;

  pong_ball #(.LEDS(LEDS)) u_ball (
    .clk_i, .rst_ni, .tick_i,
    .hit_a_i   (hit_a),
    .hit_b_i   (hit_b),
    .pickup_i,
    .play_en_i (!game_over_o),
    .server_i  (owner),
    .launch_o  (launch),
    .miss_a_o  (miss_a),
    .miss_b_o  (miss_b),
    .led_o
  );

  pong_serve #(.SERVES(SERVES)) u_serve (
    .clk_i, .rst_ni,
    .launch_i (launch),
    .owner_o  (owner)
  );

  // a miss by one side scores for the other
  pong_score #(.W(SCORE_W), .WIN(WIN)) u_score_a (
    .clk_i, .rst_ni,
    .clr_i   (ref_clr_i),
    .inc_i   (miss_b && !game_over_o),
    .score_o (score_a_o),
    .win_o   (win_a)
  );

  pong_score #(.W(SCORE_W), .WIN(WIN)) u_score_b (
    .clk_i, .rst_ni,
    .clr_i   (ref_clr_i),
    .inc_i   (miss_a && !game_over_o),
    .score_o (score_b_o),
    .win_o   (win_b)
  );

  assign game_over_o = win_a || win_b;
  assign serve_led_o = (owner == SIDE_A) ? 2'b01 : 2'b10;

  p_one_server_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(serve_led_o) == 1);
  p_frozen_over_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (game_over_o && !ref_clr_i) |=> $stable(score_a_o) && $stable(score_b_o));
endmodule

// File: tb/tb_pong_core.sv
module tb_pong_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, pad_a = 1'b0, pad_b = 1'b0, pickup = 1'b0, clr = 1'b0;
  logic [7:0] led;
  logic [1:0] serve_led;
  logic [3:0] sa, sb;
  logic       over;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  pong_core dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .paddle_a_i(pad_a),
    .paddle_b_i(pad_b), .pickup_i(pickup), .ref_clr_i(clr), .led_o(led),
    .serve_led_o(serve_led), .score_a_o(sa), .score_b_o(sb), .game_over_o(over)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic press(input bit side_b);
    if (side_b) pad_b = 1'b1; else pad_a = 1'b1;
    cyc();
    pad_a = 1'b0;
    pad_b = 1'b0;
    cyc();
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      cyc();
      tick = 1'b0;
    end
  endtask

  task automatic pick();
    pickup = 1'b1;
    cyc();
    pickup = 1'b0;
  endtask

  function automatic logic [7:0] at(input int p);
    return (p >= 1 && p <= 8) ? 8'(1) << (p - 1) : 8'h00;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int  exp_sa, exp_sb, cnt, guard;
    bit  own_b, launcher_b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc();
    // R1 reset state
    chk("R1 led", led, at(1));
    chk("R1 serve", serve_led, 2'b01);
    chk("R1 scores", {sa, sb}, 8'h00);
    chk("R1 over", over, 1'b0);

    // R4 non-server press and pre-launch tick
    press(1'b1);
    ticks(1);
    chk("R4 idle", led, at(1));
    // R3 launch by A, step per tick
    press(1'b0);
    chk("R3 launch no move", led, at(1));
    for (int p = 2; p <= 8; p++) begin
      ticks(1);
      chk("R2 R3 up", led, at(p));
    end
    // R5 rebound by B
    press(1'b1);
    ticks(4);
    chk("R5 rebound", led, at(4));
    press(1'b0);
    ticks(1);
    chk("R5 ignored mid press", led, at(3));
    ticks(3);
    chk("R6 out low", led, 8'h00);
    chk("R6 B scores", {sa, sb}, {4'd0, 4'd1});
    ticks(2);
    press(1'b0);
    chk("R6 stays out", led, 8'h00);
    chk("R6 scored once", {sa, sb}, {4'd0, 4'd1});

    // R7 pickup, second A serve flips owner (R8)
    pick();
    chk("R7 pickup A end", led, at(1));
    chk("R8 one serve", serve_led, 2'b01);
    press(1'b0);
    chk("R8 flip", serve_led, 2'b10);
    ticks(4);
    pad_b = 1'b1;
    ticks(3);
    chk("R11 held at end", led, at(8));
    ticks(1);
    chk("R11 no hit", led, 8'h00);
    chk("R6 A scores", {sa, sb}, {4'd1, 4'd1});
    pad_b = 1'b0;
    cyc();

    // R7 pickup B end, R4 A ignored
    pick();
    chk("R7 pickup B end", led, at(8));
    press(1'b0);
    ticks(1);
    chk("R4 no move before B serve", led, at(8));
    press(1'b1);
    ticks(1);
    chk("R3 B launch down", led, at(7));
    ticks(7);
    chk("R6 out low 2", {sa, sb, led}, {4'd1, 4'd2, 8'h00});

    // full game
    exp_sa = 1; exp_sb = 2; own_b = 1'b1; cnt = 1; guard = 0;
    while (exp_sa < 11 && exp_sb < 11 && guard < 40) begin
      guard++;
      pick();
      chk("R7 server end", led, own_b ? at(8) : at(1));
      launcher_b = own_b;
      press(own_b);
      cnt++;
      if (cnt == 2) begin cnt = 0; own_b = !own_b; end
      chk("R8 owner", serve_led, own_b ? 2'b10 : 2'b01);
      ticks(8);
      if (launcher_b) exp_sb++; else exp_sa++;
      chk("R6 rally score", {sa, sb}, {4'(exp_sa), 4'(exp_sb)});
    end
    chk("R9 over", over, 1'b1);
    chk("R9 final", {sa, sb}, {4'd9, 4'd11});
    pick();
    press(own_b);
    press(!own_b);
    ticks(9);
    chk("R9 launch blocked", led, own_b ? at(8) : at(1));
    chk("R9 saturated", {sa, sb}, {4'd9, 4'd11});
    clr = 1'b1;
    cyc();
    clr = 1'b0;
    chk("R10 cleared", {sa, sb}, 8'h00);
    chk("R10 over low", over, 1'b0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule